// File: doc/BRIEF.md
# Vector Length Control Register Unit

This unit holds the loop-length settings of a scalar core that repeats each instruction over a run of elements. It has two length registers. VL is the number of elements the next instruction covers. MVL is the upper limit VL may take. A third view, STATE, packs both lengths into one word so that a context switch can save and restore them with one access. A core sends each CSR access here: the address, the operation, and either a register source value or a 5-bit immediate. The unit answers in the same cycle with the value to write back to rd. Its register contents change at the next clock edge. The current VL and MVL are exported for an element-loop sequencer.

Accesses to VL work differently from ordinary CSRs. The hardware never picks its own length: the requested length is stored as given, and is changed only when it falls outside 1..MVL. The value returned to rd is the newly stored length, not the old one. MVL and STATE follow the usual rule: the old contents are returned and the new contents are stored.

Top module: `vlcsr_top`

## Requirements
- R1: After reset, curMvl equals XLEN and curVl equals 1.
- R2: A write (csrOp=01) to address 0x7C0 from the register source with a value in 1..MVL stores exactly that value in VL. VL=1 is a legal setting and leaves MVL unchanged.
- R3: A register-source VL write of 0 stores 1. A value above MVL stores MVL.
- R4: Every hit on address 0x7C0 returns the new VL, zero-extended, on rdData in the access cycle.
- R5: A VL write from the immediate (csrUseImm=1) requests immediate+1, so 0..31 selects 1..32, and the request is then clamped to MVL.
- R6: Set (csrOp=10) and clear (csrOp=11) on VL OR or AND-NOT the operand into the current VL. The result is clamped as in R3.
- R7: Address 0x7C1 (MVL) returns the old MVL. A write stores the operand clamped to 1..XLEN, and VL is lowered to the new MVL if it exceeds it.
- R8: Address 0x7C2 (STATE) returns the old word, with VL-1 in bits [5:0] and MVL-1 in bits [11:6] (for XLEN=64). A write restores MVL from bits [11:6]+1 and VL from bits [5:0]+1, with VL clamped to the restored MVL. The immediate is used unchanged.
- R9: When rdIsZero is high, the register update still happens, but rdWrite stays low.
- R10: An access to any other address, or with csrOp=00, gives csrHit=0 and rdWrite=0, and leaves VL and MVL unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csrValid | input | 1 | CSR access present this cycle |
| csrAddr | input | 12 | CSR address |
| csrOp | input | 2 | 01 write, 10 set, 11 clear, 00 none |
| csrUseImm | input | 1 | Take operand from csrImm instead of csrRs1 |
| csrRs1 | input | XLEN | Register source operand |
| csrImm | input | 5 | Immediate operand |
| rdIsZero | input | 1 | Destination is the zero register |
| csrHit | output | 1 | Access targets one of the three registers |
| rdWrite | output | 1 | Write rdData to the destination register |
| rdData | output | XLEN | Value for the destination register |
| curVl | output | $clog2(XLEN)+1 | Current VL |
| curMvl | output | $clog2(XLEN)+1 | Current MVL |

## Verification
The bench builds the unit with XLEN=64. This gives 6-bit STATE fields and an MVL large enough that every immediate request (1..32) is stored without clamping. Register-source values such as 100 and 200 exceed XLEN, which exercises both clamps. MVL is then lowered to 8 and to 1 through its own CSR, which brings the immediate clamp and the lowering of VL within reach. STATE words restore an MVL of 16 and of 32.

// File: rtl/vlcsr_pkg.sv
package vlcsr_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_WRITE = 2'b01,
    OP_SET   = 2'b10,
    OP_CLEAR = 2'b11
  } csrOpE;

  // strobes from control to datapath
  typedef struct packed {
    logic selVl;
    logic selMvl;
    logic selState;
    logic update;
    logic rdWe;
  } csrStrobeT;

endpackage

// File: rtl/vlcsr_ctrl.sv
module vlcsr_ctrl
  import vlcsr_pkg::*;
#(
  parameter logic [11:0] ADDR_VL    = 12'h7C0,
  parameter logic [11:0] ADDR_MVL   = 12'h7C1,
  parameter logic [11:0] ADDR_STATE = 12'h7C2
) (
  input  logic        csrValid,
  input  logic [11:0] csrAddr,
  input  logic [1:0]  csrOp,
  input  logic        rdIsZero,
  output csrStrobeT   strobe,
  output logic        csrHit
);

  logic opLive;
  logic hitVl, hitMvl, hitState;

  always_comb begin
    opLive   = csrValid && (csrOp != OP_NONE);
    hitVl    = opLive && (csrAddr == ADDR_VL);
    hitMvl   = opLive && (csrAddr == ADDR_MVL);
    hitState = opLive && (csrAddr == ADDR_STATE);
    csrHit   = hitVl || hitMvl || hitState;

    strobe.selVl    = hitVl;
    strobe.selMvl   = hitMvl;
    strobe.selState = hitState;
    strobe.update   = csrHit;
    strobe.rdWe     = csrHit && !rdIsZero;
  end

endmodule

// File: rtl/vlcsr_datapath.sv
module vlcsr_datapath
  import vlcsr_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int FW = $clog2(XLEN),
  localparam int LW = FW + 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  csrStrobeT       strobe,
  input  logic [1:0]      csrOp,
  input  logic            csrUseImm,
  input  logic [XLEN-1:0] csrRs1,
  input  logic [4:0]      csrImm,
  output logic [XLEN-1:0] rdData,
  output logic [LW-1:0]   curVl,
  output logic [LW-1:0]   curMvl
);

  logic [LW-1:0] vlQ, mvlQ;

  // force a requested length into 1..lim
  function automatic logic [LW-1:0] clampLen(input logic [XLEN-1:0] raw,
                                             input logic [LW-1:0] lim);
    if (raw == '0)                 return LW'(1);
    else if (raw > XLEN'(lim))     return lim;
    else                           return raw[LW-1:0];
  endfunction

  // bit operation applied to current value; plain write uses writeVal
  function automatic logic [XLEN-1:0] applyOp(input logic [1:0] op,
                                              input logic [XLEN-1:0] cur,
                                              input logic [XLEN-1:0] opnd,
                                              input logic [XLEN-1:0] writeVal);
    case (op)
      OP_SET:   return cur | opnd;
      OP_CLEAR: return cur & ~opnd;
      default:  return writeVal;
    endcase
  endfunction

  logic [XLEN-1:0] operand, lenWriteVal;
  logic [XLEN-1:0] vlRaw, mvlRaw, stateRaw, stateCur;
  logic [FW-1:0]   vlField, mvlField;
  logic [LW-1:0]   vlMinus, mvlMinus;
  logic [LW-1:0]   vlFromVl, mvlFromMvl, vlFromMvl, mvlFromState, vlFromState;
  logic [LW-1:0]   vlNext, mvlNext;

  always_comb begin
    operand     = csrUseImm ? XLEN'(csrImm) : csrRs1;
    // length registers take the immediate offset by one
    lenWriteVal = csrUseImm ? (XLEN'(csrImm) + XLEN'(1)) : csrRs1;

    vlMinus  = vlQ - LW'(1);
    mvlMinus = mvlQ - LW'(1);
    vlField  = vlMinus[FW-1:0];
    mvlField = mvlMinus[FW-1:0];
    stateCur = XLEN'({mvlField, vlField});

    vlRaw    = applyOp(csrOp, XLEN'(vlQ), operand, lenWriteVal);
    mvlRaw   = applyOp(csrOp, XLEN'(mvlQ), operand, lenWriteVal);
    stateRaw = applyOp(csrOp, stateCur, operand, operand);

    vlFromVl     = clampLen(vlRaw, mvlQ);
    mvlFromMvl   = clampLen(mvlRaw, LW'(XLEN));
    vlFromMvl    = (vlQ > mvlFromMvl) ? mvlFromMvl : vlQ;
    mvlFromState = {1'b0, stateRaw[2*FW-1:FW]} + LW'(1);
    vlFromState  = clampLen(XLEN'(stateRaw[FW-1:0]) + XLEN'(1), mvlFromState);

    vlNext  = vlQ;
    mvlNext = mvlQ;
    if (strobe.update) begin
      if (strobe.selVl) begin
        vlNext = vlFromVl;
      end else if (strobe.selMvl) begin
        mvlNext = mvlFromMvl;
        vlNext  = vlFromMvl;
      end else if (strobe.selState) begin
        mvlNext = mvlFromState;
        vlNext  = vlFromState;
      end
    end

    if (strobe.selVl)         rdData = XLEN'(vlFromVl);
    else if (strobe.selMvl)   rdData = XLEN'(mvlQ);
    else if (strobe.selState) rdData = stateCur;
    else                      rdData = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vlQ  <= LW'(1);
      mvlQ <= LW'(XLEN);
    end else begin
      vlQ  <= vlNext;
      mvlQ <= mvlNext;
    end
  end

  assign curVl  = vlQ;
  assign curMvl = mvlQ;

endmodule

// File: rtl/vlcsr_top.sv
module vlcsr_top
  import vlcsr_pkg::*;
#(
  parameter int XLEN = 64,
  parameter logic [11:0] ADDR_VL    = 12'h7C0,
  parameter logic [11:0] ADDR_MVL   = 12'h7C1,
  parameter logic [11:0] ADDR_STATE = 12'h7C2,
  localparam int LW = $clog2(XLEN) + 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            csrValid,
  input  logic [11:0]     csrAddr,
  input  logic [1:0]      csrOp,
  input  logic            csrUseImm,
  input  logic [XLEN-1:0] csrRs1,
  input  logic [4:0]      csrImm,
  input  logic            rdIsZero,
  output logic            csrHit,
  output logic            rdWrite,
  output logic [XLEN-1:0] rdData,
  output logic [LW-1:0]   curVl,
  output logic [LW-1:0]   curMvl
);

  csrStrobeT strobe;

  vlcsr_ctrl #(
    .ADDR_VL(ADDR_VL), .ADDR_MVL(ADDR_MVL), .ADDR_STATE(ADDR_STATE)
  ) u_ctrl (
    .csrValid(csrValid), .csrAddr(csrAddr), .csrOp(csrOp),
    .rdIsZero(rdIsZero), .strobe(strobe), .csrHit(csrHit)
  );

  vlcsr_datapath #(.XLEN(XLEN)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .csrOp(csrOp),
    .csrUseImm(csrUseImm), .csrRs1(csrRs1), .csrImm(csrImm),
    .rdData(rdData), .curVl(curVl), .curMvl(curMvl)
  );

  assign rdWrite = strobe.rdWe;

endmodule

// File: rtl/vlcsr_checker.sv
module vlcsr_checker #(
  parameter int XLEN = 64,
  parameter logic [11:0] ADDR_VL    = 12'h7C0,
  parameter logic [11:0] ADDR_STATE = 12'h7C2,
  localparam int FW = $clog2(XLEN),
  localparam int LW = FW + 1
) (
  input logic            clk,
  input logic            rstN,
  input logic            csrValid,
  input logic [11:0]     csrAddr,
  input logic [1:0]      csrOp,
  input logic            csrUseImm,
  input logic [XLEN-1:0] csrRs1,
  input logic [4:0]      csrImm,
  input logic            rdIsZero,
  input logic            csrHit,
  input logic            rdWrite,
  input logic [XLEN-1:0] rdData,
  input logic [LW-1:0]   curVl,
  input logic [LW-1:0]   curMvl
);

  logic [LW-1:0] vlM1, mvlM1;
  assign vlM1  = curVl - LW'(1);
  assign mvlM1 = curMvl - LW'(1);

  p_vl_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    (curVl >= LW'(1)) && (curVl <= curMvl));

  p_mvl_range_r7: assert property (@(posedge clk) disable iff (!rstN)
    (curMvl >= LW'(1)) && (curMvl <= LW'(XLEN)));

  p_exact_len_r2: assert property (@(posedge clk) disable iff (!rstN)
    (csrValid && csrAddr == ADDR_VL && csrOp == 2'b01 && !csrUseImm &&
     csrRs1 >= XLEN'(1) && csrRs1 <= XLEN'(curMvl))
    |=> curVl == $past(csrRs1[LW-1:0]));

  p_new_value_r4: assert property (@(posedge clk) disable iff (!rstN)
    (csrHit && csrAddr == ADDR_VL) |=> XLEN'(curVl) == $past(rdData));

  p_imm_offset_r5: assert property (@(posedge clk) disable iff (!rstN)
    (csrHit && csrAddr == ADDR_VL && csrOp == 2'b01 && csrUseImm &&
     (LW'(csrImm) + LW'(1)) <= curMvl)
    |=> curVl == LW'($past(csrImm)) + LW'(1));

  p_old_state_r8: assert property (@(posedge clk) disable iff (!rstN)
    (csrHit && csrAddr == ADDR_STATE) |->
    rdData == XLEN'({mvlM1[FW-1:0], vlM1[FW-1:0]}));

  p_zero_dest_r9: assert property (@(posedge clk) disable iff (!rstN)
    rdIsZero |-> !rdWrite);

  p_miss_r10: assert property (@(posedge clk) disable iff (!rstN)
    !csrHit |=> $stable(curVl) && $stable(curMvl));

endmodule

bind vlcsr_top vlcsr_checker #(
  .XLEN(XLEN), .ADDR_VL(ADDR_VL), .ADDR_STATE(ADDR_STATE)
) u_chk (.*);

// File: tb/tb_vlcsr_top.sv
module tb_vlcsr_top;

  localparam int XLEN = 64;
  localparam int LW = $clog2(XLEN) + 1;
  localparam logic [11:0] A_VL = 12'h7C0, A_MVL = 12'h7C1, A_ST = 12'h7C2;
  localparam logic [1:0] WR = 2'b01, ST = 2'b10, CL = 2'b11;

  logic clk = 0, rstN = 0;
  logic csrValid = 0, csrUseImm = 0, rdIsZero = 0;
  logic [11:0] csrAddr = '0;
  logic [1:0] csrOp = '0;
  logic [XLEN-1:0] csrRs1 = '0;
  logic [4:0] csrImm = '0;
  logic csrHit, rdWrite;
  logic [XLEN-1:0] rdData;
  logic [LW-1:0] curVl, curMvl;

  int errors = 0, checks = 0, cycles = 0;
  logic [XLEN-1:0] gotRd;
  logic gotWe, gotHit;

  always #10 clk = ~clk;

  vlcsr_top #(.XLEN(XLEN)) dut (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=5000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic access(input logic [11:0] a, input logic [1:0] op,
                        input bit imm, input longint val, input bit rdz);
    @(negedge clk);
    csrValid = 1; csrAddr = a; csrOp = op; csrUseImm = imm;
    csrRs1 = XLEN'(val); csrImm = val[4:0]; rdIsZero = rdz;
    #2;
    gotRd = rdData; gotWe = rdWrite; gotHit = csrHit;
    @(posedge clk); #1;
    csrValid = 0; rdIsZero = 0;
  endtask

  task automatic testReset();
    chk("R1 vl", curVl, 1);
    chk("R1 mvl", curMvl, 64);
    access(A_ST, ST, 0, 0, 0);
    chk("R8 reset state", gotRd, 63 << 6);
  endtask

  task automatic testRegWrite();
    access(A_VL, WR, 0, 10, 0);
    chk("R4 rd", gotRd, 10); chk("R4 we", gotWe, 1);
    chk("R2 vl", curVl, 10);
    access(A_VL, WR, 0, 1, 0);
    chk("R2 scalar vl", curVl, 1); chk("R2 mvl kept", curMvl, 64);
  endtask

  task automatic testClamp();
    access(A_VL, WR, 0, 100, 0);
    chk("R3 high rd", gotRd, 64); chk("R3 high vl", curVl, 64);
    access(A_VL, WR, 0, 0, 0);
    chk("R3 zero rd", gotRd, 1); chk("R3 zero vl", curVl, 1);
  endtask

  task automatic testImm();
    access(A_VL, WR, 1, 31, 0);
    chk("R5 imm31 rd", gotRd, 32); chk("R5 imm31 vl", curVl, 32);
    access(A_VL, WR, 1, 0, 0);
    chk("R5 imm0 vl", curVl, 1);
    access(A_VL, WR, 1, 6, 0);
    chk("R5 imm6 vl", curVl, 7);
  endtask

  task automatic testSetClear();
    access(A_VL, WR, 0, 10, 0);
    access(A_VL, ST, 0, 5, 0);
    chk("R6 set rd", gotRd, 15); chk("R6 set vl", curVl, 15);
    access(A_VL, CL, 0, 3, 0);
    chk("R6 clear vl", curVl, 12);
    access(A_VL, CL, 0, 12, 0);
    chk("R6 clear to zero", curVl, 1);
    access(A_VL, ST, 0, 128, 0);
    chk("R6 set clamp", curVl, 64);
  endtask

  task automatic testMvl();
    access(A_MVL, WR, 0, 8, 0);
    chk("R7 old rd", gotRd, 64); chk("R7 mvl", curMvl, 8);
    chk("R7 vl lowered", curVl, 8);
    access(A_VL, WR, 1, 31, 0);
    chk("R5 imm clamp", curVl, 8);
    access(A_MVL, WR, 0, 200, 0);
    chk("R7 old rd2", gotRd, 8); chk("R7 mvl cap", curMvl, 64);
    chk("R7 vl kept", curVl, 8);
    access(A_MVL, WR, 0, 0, 0);
    chk("R7 mvl floor", curMvl, 1); chk("R7 vl floor", curVl, 1);
  endtask

  task automatic testState();
    access(A_ST, WR, 0, (15 << 6) | 20, 0);
    chk("R8 old rd", gotRd, 0);
    chk("R8 mvl", curMvl, 16); chk("R8 vl clamp", curVl, 16);
    access(A_ST, WR, 0, (31 << 6) | 4, 0);
    chk("R8 old rd2", gotRd, (15 << 6) | 15);
    chk("R8 mvl2", curMvl, 32); chk("R8 vl2", curVl, 5);
    access(A_ST, ST, 0, 0, 0);
    chk("R8 readback", gotRd, (31 << 6) | 4);
  endtask

  task automatic testRdZero();
    access(A_VL, WR, 0, 7, 1);
    chk("R9 we", gotWe, 0); chk("R9 hit", gotHit, 1);
    chk("R9 vl", curVl, 7);
  endtask

  task automatic testMiss();
    access(12'h123, WR, 0, 20, 0);
    chk("R10 hit", gotHit, 0); chk("R10 we", gotWe, 0);
    chk("R10 vl", curVl, 7); chk("R10 mvl", curMvl, 32);
    access(A_VL, 2'b00, 0, 20, 0);
    chk("R10 noop hit", gotHit, 0); chk("R10 noop vl", curVl, 7);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    testReset();
    testRegWrite();
    testClamp();
    testImm();
    testSetClear();
    testMvl();
    testState();
    testRdZero();
    testMiss();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule